// File: doc/BRIEF.md
# Interleaved Burst Wrap Sequencer

This block steers a single 64-byte cache block across the boundary between a 64-bit external data port and a 128-bit internal bus. Every transfer is eight beats long, with all eight quadwords valid, and it runs in one of two directions. In a fill, external data arrives and is assembled into octawords for the internal side. In a write, which covers both victim write-backs and probe reads, internal octawords are fetched and sent out one quadword per beat.

A data command opens a burst. It carries a direction and a three-bit starting quadword index chosen by the external agent. That start may echo the low address bits of the original request, or it may be any other quadword in the block. Beat n always carries quadword (start XOR n), so the two beats of each pair always fall in the same octaword. The external agent marks each beat with a valid strobe and may pause between beats. The sequencer never forwards or requests anything at a granularity finer than one octaword.

The controller is a four-state machine. **IDLE** waits for a command. **FETCH** lasts one cycle and, in the write direction only, reads one internal octaword. **XFER** counts beats. **FIN** lasts one cycle after the eighth beat. The transitions are:
- IDLE→XFER on a fill command and IDLE→FETCH on a write command.
- FETCH→XFER always.
- XFER→FETCH after the second beat of a pair in a write, unless that beat is the last.
- XFER→FIN after the eighth beat.
- FIN→IDLE, or FIN→XFER / FIN→FETCH when a new command is accepted back-to-back.

Top module: `burst_wrap_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the controller in IDLE with a zero beat count and no partial octaword held. In the cycle after reset, `beat_rdy`, `int_rreq`, `int_wvalid`, `done` and `err` are all 0.
- R2: A burst ends after exactly eight accepted beats. `done` is high for exactly one cycle: the second cycle after the clock edge that accepts the eighth beat. In a fill, this is the cycle after the last octaword pulse.
- R3: `cmd_start` is a 3-bit quadword index, latched when the command is accepted. During beat n of the burst (n = 0..7), `beat_qw` equals `cmd_start XOR n`.
- R4: In a fill (`cmd_dir` = 0), `int_wvalid` pulses for one cycle after each second beat of a pair, and never after a first beat. With that pulse, `int_widx` = `beat_qw[2:1]`, `int_wdata[63:0]` is the even quadword of the octaword and `int_wdata[127:64]` is the odd one.
- R5: In a write (`cmd_dir` = 1), the controller spends one FETCH cycle before the first beat of each pair. In that cycle `int_rreq` = 1, `int_ridx` names the octaword holding the pair, `beat_rdy` = 0, and `int_rdata` is captured at the end of the cycle.
- R6: During each write beat, `ext_wdata` is the half of the fetched octaword selected by `beat_qw[0]` (0 selects bits [63:0], 1 selects bits [127:64]).
- R7: A beat is counted only when `beat_valid` and `beat_rdy` are both high. Stalls between beats are allowed. A `beat_valid` in IDLE or FETCH has no effect on the count or the outputs.
- R8: A command that arrives while a burst is in progress (in FETCH or XFER, including the cycle of the eighth beat) raises `err` for one cycle and is otherwise ignored. The running burst's order and data are unchanged.
- R9: Commands are accepted in IDLE and in FIN. A command accepted in FIN starts the next burst at once and does not raise `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Data command strobe |
| cmd_dir | input | 1 | 0 = fill, 1 = write (victim or probe read) |
| cmd_start | input | 3 | Starting quadword index |
| beat_valid | input | 1 | External beat strobe |
| beat_rdy | output | 1 | Sequencer can take a beat this cycle |
| beat_qw | output | 3 | Quadword index of the current beat |
| ext_rdata | input | 64 | Incoming fill quadword |
| ext_wdata | output | 64 | Outgoing write quadword |
| int_wvalid | output | 1 | Assembled fill octaword valid |
| int_widx | output | 2 | Octaword index of the fill output |
| int_wdata | output | 128 | Assembled fill octaword |
| int_rreq | output | 1 | Internal octaword read request |
| int_ridx | output | 2 | Octaword index requested |
| int_rdata | input | 128 | Internal octaword, valid in the request cycle |
| done | output | 1 | Burst-complete pulse |
| err | output | 1 | Command arrived while busy |

## Verification
Two functions can fall in the same cycle. The first collision is a stray command arriving on the same edge as a counted beat, at the first and at the eighth beat. Here the error pulse must appear, and the running burst must keep its order, its data and its completion. The second collision is a command accepted in FIN while the previous burst's `done` pulse is still pending. The bench provokes it by chaining bursts back-to-back. It judges the result by `done` appearing in the first cycle of the new burst with `err` low, and by the new burst then following its own start and direction.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_XFER  = 2'd2,
        SQ_FIN   = 2'd3
    } seq_state_e;

    localparam logic DIR_FILL  = 1'b0;
    localparam logic DIR_WRITE = 1'b1;
endpackage

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
    import wrap_pkg::*;
#(
    parameter int BEATS = 8,
    localparam int IW   = $clog2(BEATS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_dir,
    input  logic [IW-1:0] cmd_start,
    input  logic          beat_valid,
    output seq_state_e    state,
    output logic [IW-1:0] cnt,
    output logic          dir,
    output logic          beat_fire,
    output logic [IW-1:0] cur_qw,
    output logic          beat_rdy,
    output logic          err,
    output logic          done
);
    seq_state_e    state_nx;
    logic [IW-1:0] start_q;
    logic          accept;
    logic          busy;
    logic          last_beat;

    assign busy      = (state == SQ_FETCH) || (state == SQ_XFER);
    assign accept    = cmd_valid && ((state == SQ_IDLE) || (state == SQ_FIN));
    assign beat_rdy  = (state == SQ_XFER);
    assign beat_fire = beat_valid && beat_rdy;
    assign last_beat = (cnt == IW'(BEATS - 1));
    assign cur_qw    = start_q ^ cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE: begin
                if (accept) state_nx = (cmd_dir == DIR_WRITE) ? SQ_FETCH : SQ_XFER;
            end
            SQ_FETCH: state_nx = SQ_XFER;
            SQ_XFER: begin
                if (beat_fire) begin
                    if (last_beat)                         state_nx = SQ_FIN;
                    else if (dir == DIR_WRITE && cnt[0])   state_nx = SQ_FETCH;
                end
            end
            SQ_FIN: begin
                if (accept) state_nx = (cmd_dir == DIR_WRITE) ? SQ_FETCH : SQ_XFER;
                else        state_nx = SQ_IDLE;
            end
        endcase
    end

    // state register and burst context
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            cnt     <= '0;
            start_q <= '0;
            dir     <= DIR_FILL;
        end else begin
            state <= state_nx;
            if (accept) begin
                cnt     <= '0;
                start_q <= cmd_start;
                dir     <= cmd_dir;
            end else if (beat_fire) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // registered pulse outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            err  <= 1'b0;
            done <= 1'b0;
        end else begin
            err  <= cmd_valid && busy;
            done <= (state == SQ_FIN);
        end
    end

    AST_BUSY_CMD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> err); // R8
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && state == SQ_XFER && !(beat_fire && last_beat)) |=> (state != SQ_IDLE && state != SQ_FIN)); // R8
    AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE) |-> (cnt == '0)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_NO_BEAT_OUTSIDE_XFER: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_XFER) |=> $stable(cnt) || $past(accept)); // R7
endmodule

// File: rtl/fill_pack.sv
module fill_pack
    import wrap_pkg::*;
#(
    parameter int QW_W  = 64,
    parameter int BEATS = 8,
    localparam int IW   = $clog2(BEATS),
    localparam int OW   = 2 * QW_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            beat_fire,
    input  logic            dir,
    input  logic            second,
    input  logic [IW-1:0]   cur_qw,
    input  logic [QW_W-1:0] ext_rdata,
    output logic            int_wvalid,
    output logic [IW-2:0]   int_widx,
    output logic [OW-1:0]   int_wdata
);
    logic [QW_W-1:0] hold_q;
    logic            hold_v;
    logic            take;

    assign take = beat_fire && (dir == DIR_FILL);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q     <= '0;
            hold_v     <= 1'b0;
            int_wvalid <= 1'b0;
            int_widx   <= '0;
            int_wdata  <= '0;
        end else begin
            int_wvalid <= 1'b0;
            if (take && !second) begin
                hold_q <= ext_rdata;
                hold_v <= 1'b1;
            end else if (take && second) begin
                hold_v     <= 1'b0;
                int_wvalid <= 1'b1;
                int_widx   <= cur_qw[IW-1:1];
                int_wdata  <= cur_qw[0] ? {ext_rdata, hold_q} : {hold_q, ext_rdata};
            end
        end
    end

    AST_PAIR_HAS_HALF: assert property (@(posedge clk) disable iff (rst)
        (take && second) |-> hold_v); // R4
    AST_FILL_PULSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        int_wvalid |-> $past(take && second)); // R4
    AST_NO_WRITE_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        int_wvalid |-> $past(dir == DIR_FILL)); // R4
endmodule

// File: rtl/victim_split.sv
module victim_split
    import wrap_pkg::*;
#(
    parameter int QW_W  = 64,
    parameter int BEATS = 8,
    localparam int IW   = $clog2(BEATS),
    localparam int OW   = 2 * QW_W
) (
    input  logic            clk,
    input  logic            rst,
    input  seq_state_e      state,
    input  logic            dir,
    input  logic            cnt_odd,
    input  logic [IW-1:0]   cur_qw,
    output logic            int_rreq,
    output logic [IW-2:0]   int_ridx,
    input  logic [OW-1:0]   int_rdata,
    output logic [QW_W-1:0] ext_wdata
);
    logic [OW-1:0] oct_q;

    assign int_rreq  = (state == SQ_FETCH);
    assign int_ridx  = cur_qw[IW-1:1];
    assign ext_wdata = (state == SQ_XFER && dir == DIR_WRITE)
                     ? (cur_qw[0] ? oct_q[OW-1:QW_W] : oct_q[QW_W-1:0])
                     : '0;

    always_ff @(posedge clk) begin
        if (rst)           oct_q <= '0;
        else if (int_rreq) oct_q <= int_rdata;
    end

    AST_FETCH_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        int_rreq |-> (dir == DIR_WRITE)); // R5
    AST_FETCH_PAIR_START: assert property (@(posedge clk) disable iff (rst)
        int_rreq |-> !cnt_odd); // R5
    AST_FETCH_THEN_XFER: assert property (@(posedge clk) disable iff (rst)
        int_rreq |=> (state == SQ_XFER)); // R5
endmodule

// File: rtl/burst_wrap_seq.sv
module burst_wrap_seq
    import wrap_pkg::*;
#(
    parameter int QW_W  = 64,
    parameter int BEATS = 8,
    localparam int IW   = $clog2(BEATS),
    localparam int OW   = 2 * QW_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic            cmd_dir,
    input  logic [IW-1:0]   cmd_start,
    input  logic            beat_valid,
    output logic            beat_rdy,
    output logic [IW-1:0]   beat_qw,
    input  logic [QW_W-1:0] ext_rdata,
    output logic [QW_W-1:0] ext_wdata,
    output logic            int_wvalid,
    output logic [IW-2:0]   int_widx,
    output logic [OW-1:0]   int_wdata,
    output logic            int_rreq,
    output logic [IW-2:0]   int_ridx,
    input  logic [OW-1:0]   int_rdata,
    output logic            done,
    output logic            err
);
    seq_state_e    state;
    logic [IW-1:0] cnt;
    logic          dir;
    logic          beat_fire;
    logic [IW-1:0] cur_qw;

    assign beat_qw = cur_qw;

    wrap_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_dir    (cmd_dir),
        .cmd_start  (cmd_start),
        .beat_valid (beat_valid),
        .state      (state),
        .cnt        (cnt),
        .dir        (dir),
        .beat_fire  (beat_fire),
        .cur_qw     (cur_qw),
        .beat_rdy   (beat_rdy),
        .err        (err),
        .done       (done)
    );

    fill_pack #(.QW_W(QW_W), .BEATS(BEATS)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .beat_fire  (beat_fire),
        .dir        (dir),
        .second     (cnt[0]),
        .cur_qw     (cur_qw),
        .ext_rdata  (ext_rdata),
        .int_wvalid (int_wvalid),
        .int_widx   (int_widx),
        .int_wdata  (int_wdata)
    );

    victim_split #(.QW_W(QW_W), .BEATS(BEATS)) u_split (
        .clk        (clk),
        .rst        (rst),
        .state      (state),
        .dir        (dir),
        .cnt_odd    (cnt[0]),
        .cur_qw     (cur_qw),
        .int_rreq   (int_rreq),
        .int_ridx   (int_ridx),
        .int_rdata  (int_rdata),
        .ext_wdata  (ext_wdata)
    );

    AST_RDY_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(int_rreq && beat_rdy)); // R5
    AST_DONE_AFTER_BURST: assert property (@(posedge clk) disable iff (rst)
        done |-> !$past(beat_rdy)); // R2
endmodule

// File: tb/sim_burst_wrap_seq.sv
module sim_burst_wrap_seq;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic         cmd_dir = 1'b0;
    logic [2:0]   cmd_start = '0;
    logic         beat_valid = 1'b0;
    logic         beat_rdy;
    logic [2:0]   beat_qw;
    logic [63:0]  ext_rdata = '0;
    logic [63:0]  ext_wdata;
    logic         int_wvalid;
    logic [1:0]   int_widx;
    logic [127:0] int_wdata;
    logic         int_rreq;
    logic [1:0]   int_ridx;
    logic [127:0] int_rdata;
    logic         done;
    logic         err;

    logic [63:0]  qd  [8];
    logic [127:0] oct [4];
    int nchk = 0;
    int nerr = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    assign int_rdata = oct[int_ridx];

    burst_wrap_seq u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    function automatic logic [2:0] wrap_idx(input logic [2:0] s, input int n);
        return s ^ 3'(n);
    endfunction

    task automatic fill_data();
        for (int i = 0; i < 8; i++) qd[i] = {$urandom, $urandom};
        for (int i = 0; i < 4; i++) oct[i] = {$urandom, $urandom, $urandom, $urandom};
    endtask

    task automatic issue(input logic d, input logic [2:0] s);
        cmd_valid = 1'b1; cmd_dir = d; cmd_start = s;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_burst(input logic d, input logic [2:0] s, input bit do_issue,
                             input int stall_pct, input int inj_beat,
                             input bit chain, input logic cd, input logic [2:0] cs);
        if (do_issue) begin
            fill_data();
            issue(d, s);
        end
        for (int n = 0; n < 8; n++) begin
            logic [2:0] qw;
            logic [1:0] o;
            logic [63:0] ew;
            qw = wrap_idx(s, n);
            if (d && (n % 2 == 0)) begin
                chk(int_rreq == 1'b1 && beat_rdy == 1'b0, "R5 fetch cycle", {int_rreq, beat_rdy}, 2'b10);
                chk(int_ridx == qw[2:1], "R5 fetch index", int_ridx, qw[2:1]);
                @(negedge clk);
            end
            for (int k = 0; k < 3 && int'($urandom % 100) < stall_pct; k++) @(negedge clk);
            chk(beat_rdy == 1'b1, "R7 ready", beat_rdy, 1'b1);
            chk(beat_qw == qw, "R3 beat order", beat_qw, qw);
            if (d) begin
                ew = qw[0] ? oct[qw[2:1]][127:64] : oct[qw[2:1]][63:0];
                chk(ext_wdata == ew, "R6 write data", ext_wdata, ew);
            end
            beat_valid = 1'b1;
            ext_rdata = qd[qw];
            if (n == inj_beat) begin
                cmd_valid = 1'b1; cmd_dir = ~d; cmd_start = ~s;
            end
            @(posedge clk); @(negedge clk);
            beat_valid = 1'b0;
            cmd_valid = 1'b0;
            if (n == inj_beat) chk(err == 1'b1, "R8 busy command", err, 1'b1);
            if (!d) begin
                if (n % 2 == 1) begin
                    o = qw[2:1];
                    chk(int_wvalid == 1'b1 && int_widx == o, "R4 octaword pulse", {int_wvalid, int_widx}, {1'b1, o});
                    chk(int_wdata == {qd[{o, 1'b1}], qd[{o, 1'b0}]}, "R4 octaword data",
                        int_wdata, {qd[{o, 1'b1}], qd[{o, 1'b0}]});
                end else begin
                    chk(int_wvalid == 1'b0, "R4 no half pulse", int_wvalid, 1'b0);
                end
            end
        end
        chk(done == 1'b0, "R2 done early", done, 1'b0);
        if (chain) begin
            fill_data();
            cmd_valid = 1'b1; cmd_dir = cd; cmd_start = cs;
        end
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        chk(done == 1'b1, "R2 done pulse", done, 1'b1);
        chk(err == 1'b0, "R9 accept in FIN", err, 1'b0);
        if (!chain) begin
            @(negedge clk);
            chk(done == 1'b0, "R2 done width", done, 1'b0);
        end
    endtask

    initial begin
        int seed_init;
        logic cd;
        logic [2:0] cs;
        bit pend;
        seed_init = $urandom(32'h5EED_0042);
        fill_data();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({beat_rdy, int_rreq, int_wvalid, done, err} == 5'b0, "R1 reset outputs",
            {beat_rdy, int_rreq, int_wvalid, done, err}, 5'b0);

        // R7 beats while idle are ignored
        beat_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(int_wvalid == 1'b0 && beat_rdy == 1'b0, "R7 idle beat", {int_wvalid, beat_rdy}, 2'b0);
        end
        beat_valid = 1'b0;
        run_burst(1'b0, 3'd5, 1'b1, 0, -1, 1'b0, 1'b0, 3'd0);

        // directed orders and directions
        run_burst(1'b0, 3'd0, 1'b1, 0, -1, 1'b0, 1'b0, 3'd0);
        run_burst(1'b0, 3'd7, 1'b1, 0, -1, 1'b0, 1'b0, 3'd0);
        run_burst(1'b1, 3'd3, 1'b1, 0, -1, 1'b0, 1'b0, 3'd0);
        run_burst(1'b1, 3'd6, 1'b1, 60, -1, 1'b0, 1'b0, 3'd0);
        run_burst(1'b0, 3'd2, 1'b1, 40, 0, 1'b0, 1'b0, 3'd0);
        run_burst(1'b1, 3'd4, 1'b1, 0, 7, 1'b0, 1'b0, 3'd0);
        // R9 back-to-back via FIN
        run_burst(1'b0, 3'd1, 1'b1, 0, -1, 1'b1, 1'b1, 3'd6);
        run_burst(1'b1, 3'd6, 1'b0, 0, 7, 1'b1, 1'b0, 3'd3);
        run_burst(1'b0, 3'd3, 1'b0, 0, -1, 1'b0, 1'b0, 3'd0);

        // R1 reset in mid burst
        fill_data();
        issue(1'b0, 3'd2);
        beat_valid = 1'b1;
        repeat (3) @(negedge clk);
        beat_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({beat_rdy, int_wvalid, done} == 3'b0, "R1 reset mid burst", {beat_rdy, int_wvalid, done}, 3'b0);
        run_burst(1'b0, 3'd4, 1'b1, 0, -1, 1'b0, 1'b0, 3'd0);

        // constrained random bursts
        cd = 1'($urandom); cs = 3'($urandom);
        pend = 1'b0;
        for (int i = 0; i < 40; i++) begin
            logic d;
            logic [2:0] s;
            bit ch;
            int inj;
            d = cd; s = cs;
            cd = 1'($urandom); cs = 3'($urandom);
            ch = ($urandom % 3 == 0) && (i < 39);
            inj = ($urandom % 4 == 0) ? int'($urandom % 8) : -1;
            run_burst(d, s, !pend, 25, inj, ch, cd, cs);
            pend = ch;
        end

        if (seed_init == 0) $display("seed note");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule